// File: doc/BRIEF.md
# Programmable Address Decode Window Unit

This block steers addresses issued by a bus master towards one of several targets. Software programs eight decode windows through a small 32-bit register port. Each window has an enable flag, a 4-bit target number, an 8-bit attribute byte, a base address and a size. The base and size are both held at 64 KB granularity, and the size is stored as size minus one. Every window also has a pair of remap registers, but only on the lowest-numbered windows, up to a build-time count, do those registers exist. A hit on such a window rewrites the upper part of the address into a new region.

Each incoming 32-bit address is compared against all enabled windows at the same time. If several windows match, the one with the lowest index wins. The block then reports a hit flag, the target number, the attribute and the translated address. The lookup path is purely combinational. Register writes are clocked and apply from the following cycle.

Top module: `addr_decode_win`

## Requirements
- R1: After reset every register reads zero, every window is disabled, and every lookup misses.
- R2: The control word of window n sits at byte offset n*16. Bit 0 is the enable, bits 7:4 the target, bits 15:8 the attribute and bits 31:16 the size minus one in 64 KB units. Bits 3:1 read back as zero.
- R3: The base word sits at n*16+4 and the low remap word at n*16+8. Each keeps only bits 31:16, and its bits 15:0 read back as zero.
- R4: Windows whose index is at or above REMAP_WIN have no remap registers. Their low remap word and their high remap word (at n*16+12) read zero, and writes to them have no effect on lookups.
- R5: A window matches when it is enabled and the lookup address equals its base in every bit that is clear in the mask {size_minus_one, 16'hFFFF}. The output target and attribute are those of the matching window.
- R6: When several windows match, the lowest-numbered one decides the outputs.
- R7: When no window matches, the hit flag is low, the target and attribute are zero, and the output address equals the input address.
- R8: A hit on a window below REMAP_WIN outputs (remap_low & ~mask) | (addr & mask). A hit on any other window passes the address unchanged. The high remap word is stored but never alters the output address.
- R9: The lookup is combinational. A register write changes lookup results from the clock edge that accepts it onward, and not before.
- R10: Register offsets that select a window index of 8 or above ignore writes and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| lookup_addr_i | input | 32 | Address to decode |
| hit_o | output | 1 | Some enabled window matched |
| target_o | output | 4 | Target number of the winning window |
| attr_o | output | 8 | Attribute of the winning window |
| xlat_addr_o | output | 32 | Translated or passed-through address |

## Verification
Read data and all four lookup outputs are combinational, so they are due in the same cycle as the address that produces them. The bench changes inputs on the falling edge and samples one nanosecond later, well away from any rising edge. A register write takes effect only at the rising edge that accepts it. The bench therefore holds a write on the port, samples the lookup before that edge to confirm the old result, and samples again just after the edge to confirm the new one. Expected values come from a shadow copy of the written registers in the bench. That copy is decoded with the masking and priority rules above and swept over thousands of addresses and every window boundary.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;

  localparam int unsigned ADDR_W = 32;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_BASE = 2'd1,
    REG_RMLO = 2'd2,
    REG_RMHI = 2'd3
  } win_reg_e;

  typedef struct packed {
    logic        en;
    logic [3:0]  tgt;
    logic [7:0]  attr;
    logic [15:0] size_m1;
    logic [15:0] base;
    logic [15:0] rm_lo;
    logic [31:0] rm_hi;
  } win_cfg_t;

  function automatic logic [31:0] ctrl_word(win_cfg_t c);
    return {c.size_m1, c.attr, c.tgt, 3'b000, c.en};
  endfunction

endpackage

// File: rtl/addr_win_regs.sv
module addr_win_regs
  import addr_win_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned REMAP_WIN = 4,
  parameter int unsigned REG_AW    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output win_cfg_t          cfg_o [NUM_WIN]
);

  localparam int unsigned SEL_W = REG_AW - 4;

  logic [SEL_W-1:0] wsel;
  win_reg_e         rsel;
  logic             sel_ok;
  logic             unused_lsb;

  assign wsel       = reg_addr_i[REG_AW-1:4];
  assign rsel       = win_reg_e'(reg_addr_i[3:2]);
  assign sel_ok     = ({1'b0, wsel} < (SEL_W+1)'(NUM_WIN));
  assign unused_lsb = ^reg_addr_i[1:0];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic        wr;
    logic        en_q;
    logic [3:0]  tgt_q;
    logic [7:0]  attr_q;
    logic [15:0] size_q;
    logic [15:0] base_q;
    logic [15:0] rm_lo_w;
    logic [31:0] rm_hi_w;

    assign wr = reg_we_i && sel_ok && (wsel == SEL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q   <= 1'b0;
        tgt_q  <= '0;
        attr_q <= '0;
        size_q <= '0;
        base_q <= '0;
      end else if (wr) begin
        if (rsel == REG_CTRL) begin
          en_q   <= reg_wdata_i[0];
          tgt_q  <= reg_wdata_i[7:4];
          attr_q <= reg_wdata_i[15:8];
          size_q <= reg_wdata_i[31:16];
        end
        if (rsel == REG_BASE) base_q <= reg_wdata_i[31:16];
      end
    end

    if (g < REMAP_WIN) begin : g_remap
      logic [15:0] lo_q;
      logic [31:0] hi_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          lo_q <= '0;
          hi_q <= '0;
        end else if (wr) begin
          if (rsel == REG_RMLO) lo_q <= reg_wdata_i[31:16];
          if (rsel == REG_RMHI) hi_q <= reg_wdata_i;
        end
      end
      assign rm_lo_w = lo_q;
      assign rm_hi_w = hi_q;
    end else begin : g_plain
      assign rm_lo_w = '0;
      assign rm_hi_w = '0;
    end

    assign cfg_o[g] = '{en: en_q, tgt: tgt_q, attr: attr_q, size_m1: size_q,
                        base: base_q, rm_lo: rm_lo_w, rm_hi: rm_hi_w};
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (sel_ok && (wsel == SEL_W'(w))) begin
        unique case (rsel)
          REG_CTRL: reg_rdata_o = ctrl_word(cfg_o[w]);
          REG_BASE: reg_rdata_o = {cfg_o[w].base, 16'h0000};
          REG_RMLO: reg_rdata_o = {cfg_o[w].rm_lo, 16'h0000};
          REG_RMHI: reg_rdata_o = cfg_o[w].rm_hi;
          default:  reg_rdata_o = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/addr_win_match.sv
module addr_win_match
  import addr_win_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  input  logic [15:0]       base_i,
  input  logic [15:0]       size_m1_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] mask_o
);

  logic [ADDR_W-1:0] diff;

  assign mask_o = {size_m1_i, 16'hFFFF};
  assign diff   = addr_i ^ {base_i, 16'h0000};
  assign hit_o  = en_i && ((diff & ~mask_o) == '0);

endmodule

// File: rtl/addr_win_pick.sv
module addr_win_pick
  import addr_win_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned REMAP_WIN = 4,
  parameter int unsigned IDX_W     = $clog2(NUM_WIN)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NUM_WIN-1:0] hit_i,
  input  logic [ADDR_W-1:0] mask_i  [NUM_WIN],
  input  logic [3:0]        tgt_i   [NUM_WIN],
  input  logic [7:0]        attr_i  [NUM_WIN],
  input  logic [15:0]       rm_lo_i [REMAP_WIN],
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [3:0]        tgt_o,
  output logic [7:0]        attr_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] xlat_w [NUM_WIN];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_xlat
    if (g < REMAP_WIN) begin : g_remap
      assign xlat_w[g] = ({rm_lo_i[g], 16'h0000} & ~mask_i[g]) | (addr_i & mask_i[g]);
    end else begin : g_pass
      logic [ADDR_W-1:0] unused_mask;
      assign unused_mask = mask_i[g];
      assign xlat_w[g]   = addr_i;
    end
  end

  // descending scan so the lowest index is written last
  always_comb begin
    hit_o  = 1'b0;
    idx_o  = '0;
    tgt_o  = '0;
    attr_o = '0;
    addr_o = addr_i;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit_i[w]) begin
        hit_o  = 1'b1;
        idx_o  = IDX_W'(w);
        tgt_o  = tgt_i[w];
        attr_o = attr_i[w];
        addr_o = xlat_w[w];
      end
    end
  end

endmodule

// File: rtl/addr_decode_win.sv
module addr_decode_win
  import addr_win_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned REMAP_WIN = 4,
  parameter int unsigned REG_AW    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [31:0]       lookup_addr_i,
  output logic              hit_o,
  output logic [3:0]        target_o,
  output logic [7:0]        attr_o,
  output logic [31:0]       xlat_addr_o
);

  localparam int unsigned IDX_W = $clog2(NUM_WIN);

  win_cfg_t          cfg     [NUM_WIN];
  logic [NUM_WIN-1:0] win_hit;
  logic [ADDR_W-1:0] win_mask [NUM_WIN];
  logic [3:0]        win_tgt  [NUM_WIN];
  logic [7:0]        win_attr [NUM_WIN];
  logic [15:0]       win_rmlo [REMAP_WIN];
  logic [IDX_W-1:0]  hit_idx;
  logic [NUM_WIN-1:0] unused_rmhi;

  addr_win_regs #(
    .NUM_WIN  (NUM_WIN),
    .REMAP_WIN(REMAP_WIN),
    .REG_AW   (REG_AW)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .cfg_o      (cfg)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    addr_win_match u_match (
      .addr_i   (lookup_addr_i),
      .en_i     (cfg[g].en),
      .base_i   (cfg[g].base),
      .size_m1_i(cfg[g].size_m1),
      .hit_o    (win_hit[g]),
      .mask_o   (win_mask[g])
    );
    assign win_tgt[g]     = cfg[g].tgt;
    assign win_attr[g]    = cfg[g].attr;
    assign unused_rmhi[g] = ^cfg[g].rm_hi;
    if (g < REMAP_WIN) begin : g_rm
      assign win_rmlo[g] = cfg[g].rm_lo;
    end else begin : g_norm
      logic unused_rmlo;
      assign unused_rmlo = ^cfg[g].rm_lo;
    end
  end

  addr_win_pick #(
    .NUM_WIN  (NUM_WIN),
    .REMAP_WIN(REMAP_WIN),
    .IDX_W    (IDX_W)
  ) u_pick (
    .addr_i (lookup_addr_i),
    .hit_i  (win_hit),
    .mask_i (win_mask),
    .tgt_i  (win_tgt),
    .attr_i (win_attr),
    .rm_lo_i(win_rmlo),
    .hit_o  (hit_o),
    .idx_o  (hit_idx),
    .tgt_o  (target_o),
    .attr_o (attr_o),
    .addr_o (xlat_addr_o)
  );

endmodule

// File: rtl/addr_decode_win_chk.sv
module addr_decode_win_chk #(
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned REMAP_WIN = 4,
  parameter int unsigned REG_AW    = 8,
  parameter int unsigned IDX_W     = $clog2(NUM_WIN)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [31:0]       reg_rdata_o,
  input logic [31:0]       lookup_addr_i,
  input logic              hit_o,
  input logic [3:0]        target_o,
  input logic [7:0]        attr_o,
  input logic [31:0]       xlat_addr_o,
  input logic [IDX_W-1:0]  hit_idx_i
);

  int unsigned win_num;
  logic        unused_lsb;

  assign win_num    = int'(reg_addr_i[REG_AW-1:4]);
  assign unused_lsb = ^reg_addr_i[1:0];

  assert_ctrl_pad_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i[3:2] == 2'd0) |-> (reg_rdata_o[3:1] == 3'b000));

  assert_low_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i[3:2] == 2'd1 || reg_addr_i[3:2] == 2'd2) |-> (reg_rdata_o[15:0] == 16'h0000));

  assert_no_remap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_num >= REMAP_WIN && win_num < NUM_WIN && reg_addr_i[3]) |-> (reg_rdata_o == 32'h0));

  assert_offset_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (xlat_addr_o[15:0] == lookup_addr_i[15:0]));

  assert_miss_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (target_o == 4'h0 && attr_o == 8'h00 && xlat_addr_o == lookup_addr_i));

  assert_plain_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && int'(hit_idx_i) >= REMAP_WIN) |-> (xlat_addr_o == lookup_addr_i));

  assert_oor_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_num >= NUM_WIN) |-> (reg_rdata_o == 32'h0));

endmodule

bind addr_decode_win addr_decode_win_chk #(
  .NUM_WIN  (NUM_WIN),
  .REMAP_WIN(REMAP_WIN),
  .REG_AW   (REG_AW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_addr_i   (reg_addr_i),
  .reg_rdata_o  (reg_rdata_o),
  .lookup_addr_i(lookup_addr_i),
  .hit_o        (hit_o),
  .target_o     (target_o),
  .attr_o       (attr_o),
  .xlat_addr_o  (xlat_addr_o),
  .hit_idx_i    (hit_idx)
);

// File: tb/addr_decode_win_bench.sv
module addr_decode_win_bench;

  localparam int NW = 8;
  localparam int RW = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] lookup_addr = '0;
  logic        hit;
  logic [3:0]  target;
  logic [7:0]  attr;
  logic [31:0] xlat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] sh_ctrl [NW];
  logic [31:0] sh_base [NW];
  logic [31:0] sh_rlo  [NW];
  logic [31:0] sh_rhi  [NW];

  always #5 clk = ~clk;

  addr_decode_win #(.NUM_WIN(NW), .REMAP_WIN(RW), .REG_AW(8)) u_addr_decode_win (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .lookup_addr_i(lookup_addr),
    .hit_o(hit), .target_o(target), .attr_o(attr), .xlat_addr_o(xlat)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkctrl(logic [31:0] size, logic [3:0] t, logic [7:0] a, logic en);
    return ((size - 32'd1) & 32'hFFFF_0000) | {16'h0, a, t, 3'b000, en};
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    int w = int'(a[7:4]);
    if (w >= NW) return 32'h0;
    case (a[3:2])
      2'd0:    return sh_ctrl[w] & 32'hFFFF_FFF1;
      2'd1:    return sh_base[w] & 32'hFFFF_0000;
      2'd2:    return (w < RW) ? (sh_rlo[w] & 32'hFFFF_0000) : 32'h0;
      default: return (w < RW) ? sh_rhi[w] : 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(logic [7:0] a);
    if (int'(a[7:4]) >= NW) return "R10";
    if (a[3:2] == 2'd0) return "R2";
    if (a[3:2] == 2'd1) return "R3";
    if (int'(a[7:4]) >= RW) return "R4";
    return (a[3:2] == 2'd2) ? "R3" : "R4";
  endfunction

  task automatic shadow_wr(input logic [7:0] a, input logic [31:0] d);
    int w = int'(a[7:4]);
    if (w < NW) begin
      case (a[3:2])
        2'd0:    sh_ctrl[w] = d;
        2'd1:    sh_base[w] = d;
        2'd2:    sh_rlo[w]  = d;
        default: sh_rhi[w]  = d;
      endcase
    end
  endtask

  task automatic model(input logic [31:0] a, output logic [44:0] res, output int win);
    res = {1'b0, 4'h0, 8'h00, a};
    win = -1;
    for (int w = NW - 1; w >= 0; w--) begin
      logic [31:0] m = {sh_ctrl[w][31:16], 16'hFFFF};
      if (sh_ctrl[w][0] && ((a & ~m) == (sh_base[w] & ~m))) begin
        win = w;
        res = {1'b1, sh_ctrl[w][7:4], sh_ctrl[w][15:8],
               (w < RW) ? ((sh_rlo[w] & ~m) | (a & m)) : a};
      end
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    shadow_wr(a, d);
    #1 reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input string req);
    logic [31:0] e;
    @(negedge clk);
    reg_addr = a;
    #1 e = exp_rd(a);
    check(reg_rdata == e, req, $sformatf("read @%h", a), 64'(reg_rdata), 64'(e));
  endtask

  task automatic lk_now(input string req);
    logic [44:0] e;
    int w;
    model(lookup_addr, e, w);
    if (req == "") req = (w < 0) ? "R7" : ((w < RW) ? "R8" : "R5");
    check({hit, target, attr, xlat} == e, req, $sformatf("lookup %h", lookup_addr),
          64'({hit, target, attr, xlat}), 64'(e));
  endtask

  task automatic lk(input logic [31:0] a, input string req);
    @(negedge clk);
    lookup_addr = a;
    #1 lk_now(req);
  endtask

  task automatic win_set(input int w, input logic [31:0] base, input logic [31:0] size,
                         input logic [3:0] t, input logic [7:0] a, input logic en,
                         input logic [31:0] rlo, input logic [31:0] rhi);
    wr(8'(w * 16 + 4), base);
    wr(8'(w * 16 + 8), rlo);
    wr(8'(w * 16 + 12), rhi);
    wr(8'(w * 16), mkctrl(size, t, a, en));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < NW; w++) begin
      sh_ctrl[w] = '0; sh_base[w] = '0; sh_rlo[w] = '0; sh_rhi[w] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1: reset state
    for (int i = 0; i < 64; i++) rd_chk(8'(i * 4), "R1");
    lk(32'h0000_0000, "R1");
    lk(32'h1000_0000, "R1");
    lk(32'hFFFF_FFFF, "R1");

    // R10: writes beyond the last window are dropped
    for (int i = 32; i < 64; i++) wr(8'(i * 4), 32'hFFFF_FFFF);
    for (int i = 0; i < 64; i++) rd_chk(8'(i * 4), "R10");
    lk(32'h1234_5678, "R10");

    // R2 R3 R4: register field sweep
    for (int i = 0; i < 64; i++) wr(8'(i * 4), 32'h9E37_79B9 * 32'(i + 1));
    for (int i = 0; i < 64; i++) rd_chk(8'(i * 4), rd_tag(8'(i * 4)));
    for (int i = 0; i < 32; i++) wr(8'(i * 4), 32'h0);

    // programmed map
    win_set(0, 32'h1000_0000, 32'h0010_0000, 4'h4, 8'h51, 1'b1, 32'h2000_0000, 32'h0);
    win_set(1, 32'h1100_0000, 32'h0002_0000, 4'h3, 8'h59, 1'b1, 32'h3004_ABCD, 32'hFFFF_FFFF);
    win_set(2, 32'h1080_0000, 32'h0001_0000, 4'h1, 8'h1E, 1'b1, 32'h0000_0000, 32'h0);
    win_set(3, 32'h1000_0000, 32'h0100_0000, 4'h2, 8'h0F, 1'b1, 32'h0800_0000, 32'h0);
    win_set(4, 32'h0400_0000, 32'h0400_0000, 4'h5, 8'h1D, 1'b1, 32'hDEAD_0000, 32'h0);
    win_set(5, 32'h1200_0000, 32'h0004_0000, 4'h6, 8'h1B, 1'b0, 32'h0, 32'h0);
    win_set(6, 32'h1200_0000, 32'h0100_0000, 4'h9, 8'h00, 1'b1, 32'h0, 32'h0);
    win_set(7, 32'h0000_1234, 32'h0200_0000, 4'h7, 8'h79, 1'b1, 32'h0, 32'h0);
    for (int i = 0; i < 32; i++) rd_chk(8'(i * 4), rd_tag(8'(i * 4)));

    // fixed expectations, independent of the model
    lk(32'h1101_2345, "R8");
    check(hit && xlat == 32'h3005_2345 && target == 4'h3, "R8", "remap w1",
          64'(xlat), 64'h3005_2345);
    lk(32'h0456_7890, "R4");
    check(hit && xlat == 32'h0456_7890 && target == 4'h5, "R4", "no remap w4",
          64'(xlat), 64'h0456_7890);
    lk(32'h1000_1234, "R6");
    check(hit && target == 4'h4 && xlat == 32'h2000_1234, "R6", "w0 over w3",
          64'({target, xlat}), 64'h4_2000_1234);
    lk(32'h1080_0010, "R6");
    check(hit && target == 4'h1 && xlat == 32'h0000_0010, "R6", "w2 over w3",
          64'({target, xlat}), 64'h1_0000_0010);
    lk(32'h1300_0000, "R7");
    check(!hit && target == 4'h0 && attr == 8'h00 && xlat == 32'h1300_0000, "R7", "miss",
          64'({hit, target, attr, xlat}), 64'h13_0000_00);
    lk(32'h0000_0005, "R5");
    check(hit && target == 4'h7 && attr == 8'h79, "R5", "w7 base masked",
          64'({target, attr}), 64'h779);

    // boundaries of every window
    for (int w = 0; w < NW; w++) begin
      logic [31:0] b = sh_base[w] & 32'hFFFF_0000;
      logic [31:0] s = {sh_ctrl[w][31:16], 16'hFFFF} + 32'd1;
      lk(b - 32'd1, "");
      lk(b, "");
      lk(b + s - 32'd1, "");
      lk(b + s, "");
    end

    // broad sweep
    for (int i = 0; i < 4096; i++) lk(32'(i) * 32'h0001_4001, "");

    // R9: write visible only after its accepting edge
    @(negedge clk);
    lookup_addr = 32'h1201_0000;
    reg_we = 1'b1; reg_addr = 8'h50;
    reg_wdata = mkctrl(32'h0004_0000, 4'h6, 8'h1B, 1'b1);
    #1 check(hit && target == 4'h9, "R9", "before edge", 64'(target), 64'h9);
    @(posedge clk);
    shadow_wr(8'h50, reg_wdata);
    #1 check(hit && target == 4'h6, "R9", "after edge", 64'(target), 64'h6);
    reg_we = 1'b0;
    lk(32'h1201_0000, "R6");
    lk(32'h1204_0000, "R6");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule